// File: doc/BRIEF.md
# Pulse-Gated Two-Channel Sample Capture Queue

This block takes two parallel ADC sample streams and keeps only the samples that arrive while a pulse window input is high. Each kept sample pair is packed into one 32-bit word and queued in a dual-clock FIFO. The write side runs on the ADC clock and the read side runs on a faster host clock. A marker bit in each word shows the first stored sample of every pulse, so the host can cut the drained stream back into separate pulses. An example is collecting many consecutive pulses at a 1 kHz repetition rate and plotting them one by one.

Both pointers cross between the two clocks as Gray code through multi-flop synchronizers. If the queue is full, samples inside the window are discarded and a sticky overflow indication is raised toward the host. The host clears it with a one-cycle clear input on its own clock. The host reads through a valid/ready handshake with the head word shown ahead of the pop.

Top module: `pulse_capture_fifo`

## Requirements
- R1: A sample pair presented on a write-clock edge is stored only if the window input is high on that same edge. Samples taken while the window is low never reach the read port.
- R2: Word layout: channel A in bits [13:0], channel B in bits [29:16], the pulse marker in bit 31, and bits 30, 15 and 14 always zero.
- R3: The marker bit is 1 only on the first stored word of each window-high interval. It is 0 on every other word. A window of a single sample gets a marked word.
- R4: Words leave the read port in the order their samples were taken, with none repeated or lost while the queue has room.
- R5: The read valid output is never high while the queue is empty. A word is removed only on a read-clock edge where both valid and ready are high.
- R6: When the queue already holds 2**ADDR_W words, later window-high samples are discarded. The stored words are the first 2**ADDR_W ones, and they are kept intact.
- R7: A discarded sample sets the overflow output, which stays high until the host pulses the clear input. The output reads low after the clear has crossed both clock domains. Overflow is low if nothing was ever discarded.
- R8: While valid is high and ready is low, valid stays high and the read data stays unchanged.
- R9: While either reset is asserted and just after release, valid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | ADC-side clock |
| wrRstN | input | 1 | Active-low asynchronous reset for the ADC side |
| pulseWin | input | 1 | Pulse window; high marks samples to keep |
| adcChA | input | 14 | Channel A sample |
| adcChB | input | 14 | Channel B sample |
| rdClk | input | 1 | Host-side clock |
| rdRstN | input | 1 | Active-low asynchronous reset for the host side |
| rdReady | input | 1 | Host accepts the head word |
| ovfClr | input | 1 | One-cycle request to clear the overflow indication |
| rdValid | output | 1 | Head word is present |
| rdData | output | 32 | Head word (layout in R2) |
| overflow | output | 1 | Sticky indication that samples were discarded |

## Verification
A sample driven on a write-clock falling edge is captured one write edge later. It is stored on the next write edge, and it appears on the read port after two or three more read-clock edges once the pointer has crossed. Because of this, the scoreboard compares words by order and not by arrival time. The monitor compares on the read-clock falling edge, before the edge that pops the word. Overflow set and clear both cross clock domains, so the bench checks them only after waiting at least 30 read cycles, which is well beyond the few edges either path needs. Queue-empty checks are made after the same margin, once the last window has closed.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CH_W      = 14;
  localparam int WORD_W    = 32;
  localparam int CH_B_LSB  = 16;
  localparam int MARK_BIT  = 31;

  // write-side strobes from control to datapath
  typedef struct packed {
    logic push;
    logic mark;
    logic drop;
  } wrStb_t;

  function automatic logic [WORD_W-1:0] packWord(input logic mark,
                                                 input logic [CH_W-1:0] chA,
                                                 input logic [CH_W-1:0] chB);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CH_W-1:0] = chA;
    w[CH_B_LSB +: CH_W] = chB;
    w[MARK_BIT] = mark;
    return w;
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              pulseWin,
  input  logic [ADDR_W:0]   rdGraySync,
  input  logic              clrTogSync,
  output wrStb_t            stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W:0]   wrGray,
  output logic              wrFull,
  output logic              ovfSticky
);
  logic              winQ;
  logic              armed;
  logic              clrSeen;
  logic [ADDR_W:0]   wrBin;
  logic [ADDR_W:0]   wrBinNext;

  assign wrFull = (wrGray == {~rdGraySync[ADDR_W:ADDR_W-1], rdGraySync[ADDR_W-2:0]});

  always_comb begin
    stb.push  = winQ && !wrFull;
    stb.drop  = winQ && wrFull;
    stb.mark  = winQ && !wrFull && armed;
    wrBinNext = wrBin + 1'b1;
  end

  assign wrAddr = wrBin[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      winQ      <= 1'b0;
      armed     <= 1'b1;
      clrSeen   <= 1'b0;
      wrBin     <= '0;
      wrGray    <= '0;
      ovfSticky <= 1'b0;
    end else begin
      winQ    <= pulseWin;
      clrSeen <= clrTogSync;
      if (stb.push) begin
        wrBin  <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
      // armed again once the window closes; spent on the first stored word
      if (!winQ)         armed <= 1'b1;
      else if (stb.push) armed <= 1'b0;
      // a drop in the same cycle as a clear wins
      if (stb.drop)                    ovfSticky <= 1'b1;
      else if (clrTogSync != clrSeen)  ovfSticky <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_rd_ctrl.sv
module cap_rd_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdReady,
  input  logic              ovfClr,
  input  logic [ADDR_W:0]   wrGraySync,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W:0]   rdGray,
  output logic              clrTog
);
  logic [ADDR_W:0] rdBin;
  logic [ADDR_W:0] rdBinNext;
  logic            pop;

  always_comb begin
    rdValid   = (rdGray != wrGraySync);
    pop       = rdValid && rdReady;
    rdBinNext = rdBin + 1'b1;
  end

  assign rdAddr = rdBin[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      clrTog <= 1'b0;
    end else begin
      if (pop) begin
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
      if (ovfClr) clrTog <= ~clrTog;
    end
  end
endmodule

// File: rtl/cap_dpath.sv
module cap_dpath
  import cap_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic [CH_W-1:0]   adcChA,
  input  logic [CH_W-1:0]   adcChB,
  input  wrStb_t            stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CH_W-1:0]   chAQ;
  logic [CH_W-1:0]   chBQ;
  logic [WORD_W-1:0] store [DEPTH];

  // sample regs share the edge that registers the window in control
  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      chAQ <= '0;
      chBQ <= '0;
    end else begin
      chAQ <= adcChA;
      chBQ <= adcChB;
    end
  end

  always_ff @(posedge wrClk) begin
    if (stb.push) store[wrAddr] <= packWord(stb.mark, chAQ, chBQ);
  end

  assign rdData = store[rdAddr];
endmodule

// File: rtl/pulse_capture_fifo.sv
module pulse_capture_fifo
  import cap_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        wrClk,
  input  logic        wrRstN,
  input  logic        pulseWin,
  input  logic [13:0] adcChA,
  input  logic [13:0] adcChB,
  input  logic        rdClk,
  input  logic        rdRstN,
  input  logic        rdReady,
  input  logic        ovfClr,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        overflow
);
  wrStb_t            wrStb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W:0]   wrGray;
  logic [ADDR_W:0]   rdGray;
  logic [ADDR_W:0]   wrGraySync;
  logic [ADDR_W:0]   rdGraySync;
  logic              wrFull;
  logic              ovfSticky;
  logic              clrTog;
  logic              clrTogSync;

  cap_wr_ctrl #(.ADDR_W(ADDR_W)) i_wrCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .pulseWin(pulseWin),
    .rdGraySync(rdGraySync), .clrTogSync(clrTogSync),
    .stb(wrStb), .wrAddr(wrAddr), .wrGray(wrGray),
    .wrFull(wrFull), .ovfSticky(ovfSticky)
  );

  cap_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .wrClk(wrClk), .wrRstN(wrRstN), .adcChA(adcChA), .adcChB(adcChB),
    .stb(wrStb), .wrAddr(wrAddr), .rdAddr(rdAddr), .rdData(rdData)
  );

  cap_rd_ctrl #(.ADDR_W(ADDR_W)) i_rdCtrl (
    .rdClk(rdClk), .rdRstN(rdRstN), .rdReady(rdReady), .ovfClr(ovfClr),
    .wrGraySync(wrGraySync), .rdValid(rdValid), .rdAddr(rdAddr),
    .rdGray(rdGray), .clrTog(clrTog)
  );

  cap_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) i_syncWrPtr (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync)
  );

  cap_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) i_syncRdPtr (
    .clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGraySync)
  );

  cap_sync #(.W(1), .STAGES(SYNC_STAGES)) i_syncClr (
    .clk(wrClk), .rstN(wrRstN), .d(clrTog), .q(clrTogSync)
  );

  cap_sync #(.W(1), .STAGES(SYNC_STAGES)) i_syncOvf (
    .clk(rdClk), .rstN(rdRstN), .d(ovfSticky), .q(overflow)
  );
endmodule

// File: rtl/cap_capture_chk.sv
module cap_capture_chk
  import cap_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic            wrClk,
  input logic            wrRstN,
  input logic            pulseWin,
  input wrStb_t          wrStb,
  input logic            wrFull,
  input logic [ADDR_W:0] wrGray,
  input logic            ovfSticky,
  input logic            rdClk,
  input logic            rdRstN,
  input logic            rdValid,
  input logic            rdReady,
  input logic [31:0]     rdData,
  input logic [ADDR_W:0] rdGray
);
  logic wrLive;
  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) wrLive <= 1'b0;
    else         wrLive <= 1'b1;
  end

  assert_gate_closed_R1: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrLive && !$past(pulseWin)) |-> !wrStb.push);

  assert_single_mark_R3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrStb.push && wrStb.mark) |=> !wrStb.mark);

  assert_full_holds_ptr_R6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFull |=> $stable(wrGray));

  assert_drop_sets_sticky_R7: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrStb.drop |=> ovfSticky);

  assert_no_pop_idle_R5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !(rdValid && rdReady) |=> $stable(rdGray));

  assert_hold_word_R8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
endmodule

bind pulse_capture_fifo cap_capture_chk #(.ADDR_W(ADDR_W)) i_capChk (
  .wrClk(wrClk), .wrRstN(wrRstN), .pulseWin(pulseWin), .wrStb(wrStb),
  .wrFull(wrFull), .wrGray(wrGray), .ovfSticky(ovfSticky),
  .rdClk(rdClk), .rdRstN(rdRstN), .rdValid(rdValid), .rdReady(rdReady),
  .rdData(rdData), .rdGray(rdGray)
);

// File: tb/test_pulse_capture_fifo.sv
`timescale 1ns/1ps
module test_pulse_capture_fifo;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic        wrClk = 0, rdClk = 0;
  logic        wrRstN = 0, rdRstN = 0;
  logic        pulseWin = 0;
  logic [13:0] adcChA = 0, adcChB = 0;
  logic        rdReady = 0, ovfClr = 0;
  logic        rdValid, overflow;
  logic [31:0] rdData;

  pulse_capture_fifo #(.ADDR_W(ADDR_W)) i_pulse_capture_fifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .pulseWin(pulseWin), .adcChA(adcChA),
    .adcChB(adcChB), .rdClk(rdClk), .rdRstN(rdRstN), .rdReady(rdReady),
    .ovfClr(ovfClr), .rdValid(rdValid), .rdData(rdData), .overflow(overflow)
  );

  always #10  wrClk = ~wrClk;   // 50 MHz
  always #3.5 rdClk = ~rdClk;

  int checks = 0, errors = 0;
  logic [31:0] expQ[$];
  int  readyMode = 1;   // 0 stall, 1 always, 2 alternate
  bit  stallMode = 0;
  int  stallCnt  = 0;
  bit  armedM    = 1;
  bit  monOn     = 0;
  bit  done      = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one sample per write cycle, model of what gets stored
  task automatic sendPulse(input int len, input int gap, input int seed);
    for (int i = 0; i < len + gap; i++) begin
      logic win;
      logic [13:0] a, b;
      win = (i < len);
      a = 14'((i * 37 + seed * 101) & 16'h3fff);
      b = 14'((16'h3fff - i * 53 - seed) & 16'h3fff);
      @(negedge wrClk);
      pulseWin = win;
      adcChA = a;
      adcChB = b;
      if (win) begin
        if (!stallMode || stallCnt < DEPTH) begin
          expQ.push_back({armedM, 1'b0, b, 2'b00, a});
          armedM = 0;
          stallCnt++;
        end
      end else begin
        armedM = 1;
      end
    end
  endtask

  task automatic waitRd(input int n);
    repeat (n) @(negedge rdClk);
  endtask

  // monitor / scoreboard
  initial begin : monitor
    bit hold = 0;
    bit tog = 0;
    logic [31:0] holdData = '0;
    wait (monOn);
    forever begin
      @(negedge rdClk);
      tog = ~tog;
      rdReady = (readyMode == 1) || (readyMode == 2 && tog);
      #1;
      if (hold) begin
        check(rdValid === 1'b1, "R8 valid held", {31'b0, rdValid}, 32'h1);
        check(rdData === holdData, "R8 data held", rdData, holdData);
      end
      if (rdValid === 1'b1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5/R1 valid with no expected word", rdData, 32'h0);
        end else if (rdReady) begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(rdData[31] === e[31], "R3 marker bit", rdData, e);
          check((rdData[30] | rdData[15] | rdData[14]) === 1'b0, "R2 zero bits", rdData, e);
          check(rdData === e, "R2/R4 word", rdData, e);
        end
      end
      hold = (rdValid === 1'b1) && !rdReady;
      holdData = rdData;
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge wrClk);
    @(negedge rdClk); #1;
    check(rdValid === 1'b0, "R9 valid in reset", {31'b0, rdValid}, 0);
    check(overflow === 1'b0, "R9 overflow in reset", {31'b0, overflow}, 0);
    @(negedge wrClk);
    wrRstN = 1; rdRstN = 1;
    waitRd(4); #1;
    check(rdValid === 1'b0, "R9 valid after reset", {31'b0, rdValid}, 0);
    monOn = 1;

    // R1 R2 R3 R4: several windows, reader always ready
    readyMode = 1;
    sendPulse(8, 5, 1);
    sendPulse(3, 2, 2);
    sendPulse(1, 4, 3);        // single-sample window, R3
    sendPulse(12, 6, 4);
    // alternating ready, R8
    readyMode = 2;
    sendPulse(10, 3, 5);
    sendPulse(1, 1, 6);
    sendPulse(7, 8, 7);
    waitRd(60); #1;
    check(expQ.size() == 0, "R1/R4 all words drained", expQ.size(), 0);
    check(rdValid === 1'b0, "R5 valid low when empty", {31'b0, rdValid}, 0);
    check(overflow === 1'b0, "R7 no overflow without drops", {31'b0, overflow}, 0);

    // R6 R7: stalled reader, fill past capacity
    readyMode = 0;
    waitRd(4);
    stallMode = 1; stallCnt = 0;
    sendPulse(10, 3, 8);
    sendPulse(10, 3, 9);       // six kept, four dropped
    sendPulse(3, 3, 10);       // all dropped
    waitRd(40); #1;
    check(overflow === 1'b1, "R7 overflow set", {31'b0, overflow}, 1);
    check(rdValid === 1'b1, "R6 full queue valid", {31'b0, rdValid}, 1);
    check(expQ.size() == DEPTH, "R6 model kept depth", expQ.size(), DEPTH);
    readyMode = 1;
    waitRd(60); #1;
    stallMode = 0;
    check(expQ.size() == 0, "R6 kept words drained", expQ.size(), 0);
    check(overflow === 1'b1, "R7 overflow sticky", {31'b0, overflow}, 1);
    ovfClr = 1;
    @(negedge rdClk);
    ovfClr = 0;
    waitRd(40); #1;
    check(overflow === 1'b0, "R7 overflow cleared", {31'b0, overflow}, 0);

    // after recovery marker and data resume normally
    sendPulse(5, 4, 11);
    sendPulse(2, 4, 12);
    waitRd(60); #1;
    check(expQ.size() == 0, "R4 final drain", expQ.size(), 0);
    check(rdValid === 1'b0, "R5 final empty", {31'b0, rdValid}, 0);
    check(overflow === 1'b0, "R7 stays clear", {31'b0, overflow}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule